// File: doc/BRIEF.md
# Video FIFO High-Priority Fill Request with Hysteresis

This block watches how many bytes sit in a video FIFO and tells the memory arbiter when the FIFO needs urgent refilling. Two 4-bit threshold fields are used, each counted in 64-byte units. The request turns on when the fill falls to the lower (start) depth. It stays on until the fill climbs back to the upper (end) depth. Between the two depths the request keeps whatever state it had, so it does not chatter around a single level.

The threshold inputs are captured only on a frame-start strobe. A change made part way through a frame therefore never disturbs the fill pattern of the frame in progress. A pair of thresholds that cannot work (start of zero, or start not strictly below end, which includes an end of zero for a disabled overlay) keeps the request off. Dropping the video-enable flag forces the output low in the same cycle and clears the internal request state.

All pins are plain control and status levels. The block carries no data stream, so it has no valid/ready handshake and applies no back-pressure. The fill count is sampled on every clock.

Top module: `vfp_prio_req`

## Requirements
- R1: While reset is asserted and after its release, `hi_prio_req` is 0 and both captured thresholds are 0, so no request can start until a frame-start strobe has loaded legal thresholds.
- R2: With the request off, legal thresholds and video enabled, the request turns on when `fill_bytes` <= start_level*64.
- R3: With the request on, it stays on while `fill_bytes` < end_level*64 and turns off once `fill_bytes` >= end_level*64.
- R4: With the request off, a fill strictly above start_level*64 does not turn it on, even when that fill is below end_level*64.
- R5: `lvl_start`/`lvl_end` are captured only in a cycle where `frame_start` is 1. In other cycles a change on them has no effect on `hi_prio_req`.
- R6: If the captured start level is 0, or the start level is not strictly less than the end level (including an end level of 0), `hi_prio_req` stays 0 whatever the fill.
- R7: When `video_en` is 0, `hi_prio_req` is 0 in that same cycle, and the request state is cleared. After re-enabling, the request reappears only from a fresh evaluation one clock later.
- R8: A change of `fill_bytes` across a threshold is reflected on `hi_prio_req` one clock edge later, not in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| video_en | input | 1 | Video path enabled; 0 forces the request off at once |
| frame_start | input | 1 | One-cycle strobe; captures the threshold inputs |
| lvl_start | input | 4 | Start depth in 64-byte units |
| lvl_end | input | 4 | End depth in 64-byte units |
| fill_bytes | input | FILL_W (12) | Current FIFO fill in bytes |
| hi_prio_req | output | 1 | High-priority fill request level to the arbiter |

## Verification
The fill count is stepped down through the start depth and up through the end depth, one byte either side of each boundary. This separates the inclusive turn-on compare from the inclusive turn-off compare, and it also shows the hysteresis band where the output keeps its previous state. Threshold inputs are changed without a strobe while a request is active, to show that only the captured values count. A set of illegal pairs (start of zero, equal levels, inverted levels, end of zero) is tried against a near-empty FIFO. Video-enable is dropped mid-request and raised again to separate the same-cycle gating from the cleared state. A long random run mixes all of these against a behavioural model.

// File: rtl/vfp_pkg.sv
package vfp_pkg;
  localparam int LVL_W      = 4;
  localparam int UNIT_SHIFT = 6;
  localparam int DEPTH_W    = LVL_W + UNIT_SHIFT;

  typedef struct packed {
    logic [LVL_W-1:0] lo;
    logic [LVL_W-1:0] hi;
  } thr_t;
endpackage

// File: rtl/vfp_thr_shadow.sv
module vfp_thr_shadow
  import vfp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  thr_t thr_in,
  output thr_t thr_q,
  output logic legal
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           thr_q <= '0;
    else if (frame_start) thr_q <= thr_in;
  end

  // usable only with a non-zero start strictly below the end
  always_comb legal = (thr_q.lo != '0) && (thr_q.lo < thr_q.hi);

  AST_THR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> thr_q == $past(thr_q)); // R5
  AST_THR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> thr_q == $past(thr_in)); // R5
endmodule

// File: rtl/vfp_level_cmp.sv
module vfp_level_cmp
  import vfp_pkg::*;
#(
  parameter int FILL_W = 12
) (
  input  logic [FILL_W-1:0] fill,
  input  thr_t              thr,
  output logic              at_start,
  output logic              at_end
);
  localparam int PAD = FILL_W - DEPTH_W;

  logic [DEPTH_W-1:0] lo_bytes, hi_bytes;
  logic [FILL_W-1:0]  lo_cmp, hi_cmp;

  always_comb begin
    lo_bytes = {thr.lo, {UNIT_SHIFT{1'b0}}};
    hi_bytes = {thr.hi, {UNIT_SHIFT{1'b0}}};
  end

  generate
    if (PAD > 0) begin : g_pad
      always_comb begin
        lo_cmp = {{PAD{1'b0}}, lo_bytes};
        hi_cmp = {{PAD{1'b0}}, hi_bytes};
      end
    end else begin : g_same
      always_comb begin
        lo_cmp = lo_bytes[FILL_W-1:0];
        hi_cmp = hi_bytes[FILL_W-1:0];
      end
    end
  endgenerate

  always_comb begin
    at_start = (fill <= lo_cmp);
    at_end   = (fill >= hi_cmp);
  end
endmodule

// File: rtl/vfp_hyst_ctl.sv
module vfp_hyst_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic video_en,
  input  logic legal,
  input  logic at_start,
  input  logic at_end,
  output logic req_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  req_q <= 1'b0;
    else if (!video_en || !legal) req_q <= 1'b0;
    else if (req_q)              req_q <= !at_end;
    else                         req_q <= at_start;
  end

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !legal |=> !req_q); // R6
  AST_VIDEO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !video_en |=> !req_q); // R7
  AST_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(at_start)); // R2
  AST_FALL_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(req_q) && $past(video_en) && $past(legal)) |-> $past(at_end)); // R3
endmodule

// File: rtl/vfp_prio_req.sv
module vfp_prio_req
  import vfp_pkg::*;
#(
  parameter int FILL_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              video_en,
  input  logic              frame_start,
  input  logic [LVL_W-1:0]  lvl_start,
  input  logic [LVL_W-1:0]  lvl_end,
  input  logic [FILL_W-1:0] fill_bytes,
  output logic              hi_prio_req
);
  thr_t thr_in, thr_q;
  logic legal, at_start, at_end, req_q;

  always_comb begin
    thr_in.lo = lvl_start;
    thr_in.hi = lvl_end;
  end

  vfp_thr_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .thr_in(thr_in), .thr_q(thr_q), .legal(legal)
  );

  vfp_level_cmp #(.FILL_W(FILL_W)) u_cmp (
    .fill(fill_bytes), .thr(thr_q), .at_start(at_start), .at_end(at_end)
  );

  vfp_hyst_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .video_en(video_en), .legal(legal),
    .at_start(at_start), .at_end(at_end), .req_q(req_q)
  );

  // gating keeps the release immediate when video is switched off
  assign hi_prio_req = req_q & video_en;

  AST_OFF_IN_RESET: assert property (@(posedge clk) !rst_n |-> !hi_prio_req); // R1
endmodule

// File: tb/vfp_prio_req_test.sv
module vfp_prio_req_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        video_en = 1'b0;
  logic        frame_start = 1'b0;
  logic [3:0]  lvl_start = '0;
  logic [3:0]  lvl_end = '0;
  logic [11:0] fill_bytes = '0;
  logic        hi_prio_req;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit cmp_en = 0;
  string tag = "R1";

  int m_lo = 0, m_hi = 0;
  bit m_req = 0;

  always #5 clk = ~clk;

  vfp_prio_req uut (
    .clk(clk), .rst_n(rst_n), .video_en(video_en), .frame_start(frame_start),
    .lvl_start(lvl_start), .lvl_end(lvl_end), .fill_bytes(fill_bytes),
    .hi_prio_req(hi_prio_req)
  );

  // behavioural reference: state updated at each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_req = 0; m_lo = 0; m_hi = 0;
    end else begin
      bit ok, nxt;
      ok = (m_lo != 0) && (m_lo < m_hi);
      if (!video_en || !ok) nxt = 0;
      else if (m_req)       nxt = (int'(fill_bytes) < m_hi * 64);
      else                  nxt = (int'(fill_bytes) <= m_lo * 64);
      m_req = nxt;
      if (frame_start) begin
        m_lo = int'(lvl_start); m_hi = int'(lvl_end);
      end
    end
  end

  task automatic check(string req, bit got, bit exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: hi_prio_req=%0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !done) check(tag, hi_prio_req, m_req && video_en);
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #2; end
  endtask

  task automatic load(int lo, int hi);
    lvl_start = 4'(lo); lvl_end = 4'(hi); frame_start = 1'b1;
    tick();
    frame_start = 1'b0;
  endtask

  initial begin
    tick(3);
    tag = "R1";
    check("R1", hi_prio_req, 1'b0);
    rst_n = 1'b1;
    cmp_en = 1;
    video_en = 1'b1;
    fill_bytes = 12'd10;
    tick(2);
    check("R1", hi_prio_req, 1'b0);

    // thresholds presented but not strobed
    tag = "R5";
    lvl_start = 4'd4; lvl_end = 4'd8;
    tick(3);
    check("R5", hi_prio_req, 1'b0);

    fill_bytes = 12'd600;
    load(4, 8);
    tag = "R4";
    fill_bytes = 12'd300; tick(2);
    fill_bytes = 12'd257; tick(2);
    check("R4", hi_prio_req, 1'b0);

    tag = "R8";
    fill_bytes = 12'd256; #1;
    check("R8", hi_prio_req, 1'b0);
    tick();
    tag = "R2";
    check("R2", hi_prio_req, 1'b1);

    tag = "R3";
    fill_bytes = 12'd400; tick(2);
    fill_bytes = 12'd511; tick(2);
    check("R3", hi_prio_req, 1'b1);
    fill_bytes = 12'd512; tick();
    check("R3", hi_prio_req, 1'b0);
    tag = "R4";
    fill_bytes = 12'd300; tick(2);
    check("R4", hi_prio_req, 1'b0);
    fill_bytes = 12'd100; tick();
    check("R2", hi_prio_req, 1'b1);

    // unstrobed change mid-request must not alter the end depth
    tag = "R5";
    lvl_start = 4'd1; lvl_end = 4'd2;
    fill_bytes = 12'd200; tick(3);
    check("R5", hi_prio_req, 1'b1);
    load(1, 2);
    tick();
    check("R5", hi_prio_req, 1'b0);

    tag = "R6";
    fill_bytes = 12'd0;
    load(0, 5); tick(2); check("R6", hi_prio_req, 1'b0);
    load(6, 6); tick(2); check("R6", hi_prio_req, 1'b0);
    load(7, 3); tick(2); check("R6", hi_prio_req, 1'b0);
    load(3, 0); tick(2); check("R6", hi_prio_req, 1'b0);

    load(4, 8);
    fill_bytes = 12'd100; tick(2);
    check("R2", hi_prio_req, 1'b1);
    tag = "R7";
    video_en = 1'b0; #1;
    check("R7", hi_prio_req, 1'b0);
    tick(2);
    video_en = 1'b1; #1;
    check("R7", hi_prio_req, 1'b0);
    tick();
    check("R7", hi_prio_req, 1'b1);

    tag = "R3";
    for (int i = 0; i < 2000; i++) begin
      fill_bytes = 12'($urandom_range(0, 1100));
      video_en = ($urandom_range(0, 19) != 0);
      if ($urandom_range(0, 40) == 0) begin
        lvl_start = 4'($urandom_range(0, 15));
        lvl_end = 4'($urandom_range(0, 15));
        frame_start = 1'b1;
      end else begin
        frame_start = 1'b0;
      end
      tick();
    end
    frame_start = 1'b0;
    tick(2);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run did not end, actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule